// File: doc/BRIEF.md
# Cascaded FIFO Cell Chain

This block builds one deep first-in first-out buffer out of a ring of identical small buffer cells. Every cell sees the same write strobe, read strobe and write data. Ownership of writing and ownership of reading each move around the ring as a token. Only the cell that holds the write token stores the incoming word. Only the cell that holds the read token returns a word. When a cell stores into or reads from its last physical location, it sends a one-cycle pass pulse on its expansion output to the next cell. The last cell sends its pulse back to the first. The receiving cell takes the token at the same clock edge, so back-to-back transfers never stall at a cell boundary.

The cell whose first-load input is tied low holds both tokens after reset. All other cells have first-load high. Every cell keeps its own pointers and occupancy count, and reports active-low empty and full flags that are qualified by the token it holds. The top level ANDs these active-low levels, so the composite flag asserts as soon as any one cell asserts it. Retransmit and a half-full indication are not part of this mode. Operation is fully synchronous to one clock.

Top module: `fifoDepthChain`

## Requirements
- R1: While reset is held and in the first cycle after it, `emptyN` is 0, `fullN` is 1 and `rdValid` is 0.
- R2: A write is stored only when `fullN` is 1 at the clock edge; a write presented while `fullN` is 0 is dropped and never appears at the read side.
- R3: A read is accepted only when `emptyN` is 1 at the clock edge; a read presented while `emptyN` is 0 produces no `rdValid` pulse.
- R4: For each accepted read, `rdValid` is 1 for exactly the following cycle with the word on `rdData`; whenever `rdValid` is 0, `rdData` is all zeros.
- R5: Words leave the chain in the same order they were accepted, including across the boundary where the write token passes from one cell to the next after that cell's last location.
- R6: The read token passes from cell to cell in the same ring order after each cell's last location is read, so reads continue across cell boundaries without an idle cycle.
- R7: `fullN` is 0 exactly when the number of stored words equals NUM_CELLS*CELL_DEPTH.
- R8: `emptyN` is 0 exactly when no word is stored.
- R9: A read and a write presented in the same cycle while the chain is neither empty nor full are both accepted.
- R10: After the tokens wrap from the last cell back to the first, more than once, order and flags stay correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all cells |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request, shared by all cells |
| wrData | input | DATA_W | Write word, shared by all cells |
| rdEn | input | 1 | Read request, shared by all cells |
| rdData | output | DATA_W | Read word, driven by the cell that served the read, zero otherwise |
| rdValid | output | 1 | One-cycle pulse marking a word on rdData |
| emptyN | output | 1 | Composite empty flag, active low |
| fullN | output | 1 | Composite full flag, active low |

## Verification
The bench builds the chain with three cells of four words each, nine bits wide, for a capacity of twelve. With a cell this shallow, a handful of transfers already moves each token across every boundary. Filling and draining the whole ring takes only a few dozen cycles, so both tokens wrap from the last cell back to the first many times. Combined reads and writes at the empty and full limits are driven as well.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

  // Per-cycle strobes from a cell's control to its storage.
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } cellStrobeT;

  // Token hand-off pulses travelling from one cell to the next.
  typedef struct packed {
    logic wrPass;
    logic rdPass;
  } tokenPulseT;

endpackage

// File: rtl/fifoCellCtrl.sv
module fifoCellCtrl
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       firstLoadN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  tokenPulseT xi,
  output tokenPulseT xo,
  output cellStrobeT strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic       cellEmptyN,
  output logic       cellFullN
);

  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          hasWrTok, hasRdTok;
  logic          isFull, isEmpty;
  logic          wrAtEnd, rdAtEnd;

  always_comb begin
    isFull        = (count == CW'(DEPTH));
    isEmpty       = (count == '0);
    wrAtEnd       = (wrPtr == AW'(DEPTH - 1));
    rdAtEnd       = (rdPtr == AW'(DEPTH - 1));
    strobe.wrStb  = wrEn && hasWrTok && !isFull;
    strobe.rdStb  = rdEn && hasRdTok && !isEmpty;
    xo.wrPass     = strobe.wrStb && wrAtEnd;
    xo.rdPass     = strobe.rdStb && rdAtEnd;
  end

  assign wrAddr     = wrPtr;
  assign rdAddr     = rdPtr;
  // Flags count only for the side whose token this cell holds.
  assign cellEmptyN = !(hasRdTok && isEmpty);
  assign cellFullN  = !(hasWrTok && isFull);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      hasWrTok <= !firstLoadN;
      hasRdTok <= !firstLoadN;
    end else begin
      if (strobe.wrStb) wrPtr <= wrAtEnd ? '0 : wrPtr + AW'(1);
      if (strobe.rdStb) rdPtr <= rdAtEnd ? '0 : rdPtr + AW'(1);

      case ({strobe.wrStb, strobe.rdStb})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase

      if (xi.wrPass)      hasWrTok <= 1'b1;
      else if (xo.wrPass) hasWrTok <= 1'b0;

      if (xi.rdPass)      hasRdTok <= 1'b1;
      else if (xo.rdPass) hasRdTok <= 1'b0;
    end
  end

endmodule

// File: rtl/fifoCellStore.sv
module fifoCellStore
  import fifo_chain_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cellStrobeT        strobe,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdWord,
  output logic              rdValid
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wordQ;
  logic              validQ;

  always_ff @(posedge clk) begin
    if (strobe.wrStb) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ  <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobe.rdStb;
      if (strobe.rdStb) wordQ <= mem[rdAddr];
    end
  end

  // A cell that did not serve the read leaves the shared bus at zero.
  assign rdWord  = validQ ? wordQ : '0;
  assign rdValid = validQ;

endmodule

// File: rtl/fifoChainCell.sv
module fifoChainCell
  import fifo_chain_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              firstLoadN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  tokenPulseT        xi,
  output tokenPulseT        xo,
  output logic [DATA_W-1:0] rdWord,
  output logic              rdValid,
  output logic              cellEmptyN,
  output logic              cellFullN
);

  cellStrobeT    strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  fifoCellCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .firstLoadN (firstLoadN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .xi         (xi),
    .xo         (xo),
    .strobe     (strobe),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .cellEmptyN (cellEmptyN),
    .cellFullN  (cellFullN)
  );

  fifoCellStore #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .wrData  (wrData),
    .rdWord  (rdWord),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/fifoDepthChain.sv
module fifoDepthChain
  import fifo_chain_pkg::*;
#(
  parameter int DATA_W     = 9,
  parameter int CELL_DEPTH = 4,
  parameter int NUM_CELLS  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              emptyN,
  output logic              fullN
);

  tokenPulseT              passV  [NUM_CELLS];
  logic [DATA_W-1:0]       wordV  [NUM_CELLS];
  logic [NUM_CELLS-1:0]    validV;
  logic [NUM_CELLS-1:0]    emptyV;
  logic [NUM_CELLS-1:0]    fullV;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    localparam int PREV = (i == 0) ? NUM_CELLS - 1 : i - 1;
    fifoChainCell #(.DATA_W(DATA_W), .DEPTH(CELL_DEPTH)) u_cell (
      .clk        (clk),
      .rstN       (rstN),
      .firstLoadN ((i == 0) ? 1'b0 : 1'b1),
      .wrEn       (wrEn),
      .wrData     (wrData),
      .rdEn       (rdEn),
      .xi         (passV[PREV]),
      .xo         (passV[i]),
      .rdWord     (wordV[i]),
      .rdValid    (validV[i]),
      .cellEmptyN (emptyV[i]),
      .cellFullN  (fullV[i])
    );
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CELLS; i++) rdData = rdData | wordV[i];
  end

  assign rdValid = |validV;
  assign emptyN  = &emptyV;
  assign fullN   = &fullV;

endmodule

// File: rtl/fifoDepthChainChk.sv
module fifoDepthChainChk #(
  parameter int DATA_W   = 9,
  parameter int CAPACITY = 12,
  localparam int CNT_W = $clog2(CAPACITY + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              emptyN,
  input logic              fullN
);

  logic [CNT_W-1:0] occ;
  logic             takeWr, takeRd;

  assign takeWr = wrEn && fullN;
  assign takeRd = rdEn && emptyN;

  always_ff @(posedge clk) begin
    if (!rstN) occ <= '0;
    else case ({takeWr, takeRd})
      2'b10:   occ <= occ + CNT_W'(1);
      2'b01:   occ <= occ - CNT_W'(1);
      default: occ <= occ;
    endcase
  end

  // R8
  empty_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyN == (occ != '0));

  // R7
  full_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullN == (occ != CNT_W'(CAPACITY)));

  // R3
  no_read_on_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !emptyN) |=> !rdValid);

  // R4
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn && emptyN));

  // R4
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  // R9
  both_accepted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn && emptyN && fullN) |=> (emptyN && fullN && rdValid));

endmodule

bind fifoDepthChain fifoDepthChainChk #(
  .DATA_W   (DATA_W),
  .CAPACITY (NUM_CELLS * CELL_DEPTH)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .rdData  (rdData),
  .rdValid (rdValid),
  .emptyN  (emptyN),
  .fullN   (fullN)
);

// File: tb/fifoDepthChain_tb.sv
module fifoDepthChain_tb;

  localparam int DW  = 9;
  localparam int CD  = 4;
  localparam int NC  = 3;
  localparam int CAP = NC * CD;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          rdEn = 1'b0;
  logic [DW-1:0] rdData;
  logic          rdValid;
  logic          emptyN;
  logic          fullN;

  always #10 clk = ~clk;

  fifoDepthChain #(.DATA_W(DW), .CELL_DEPTH(CD), .NUM_CELLS(NC)) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .rdEn    (rdEn),
    .rdData  (rdData),
    .rdValid (rdValid),
    .emptyN  (emptyN),
    .fullN   (fullN)
  );

  int            tests = 0;
  int            fails = 0;
  int            mdlCnt = 0;
  logic [DW-1:0] expQ[$];
  bit            expRd = 0;
  bit            monOn = 0;
  bit            finished = 0;
  string         curTag = "R5";
  logic [15:0]   lfsr = 16'hACE1;
  logic [DW-1:0] nextWord = 9'h001;

  task automatic check(input logic actual, input logic expected, input string req);
    tests++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, actual, expected, $time);
    end
  endtask

  // Driver: checks flags against the model, then presents one cycle of stimulus.
  task automatic step(input bit w, input logic [DW-1:0] d, input bit r, input string tag);
    bit wrOk, rdOk;
    @(negedge clk);
    check(emptyN, mdlCnt != 0, "R8");
    check(fullN, mdlCnt != CAP, "R7");
    curTag = tag;
    wrEn   = w;
    wrData = d;
    rdEn   = r;
    rdOk   = r && (mdlCnt > 0);
    wrOk   = w && (mdlCnt < CAP);
    expRd  = rdOk;
    if (wrOk) expQ.push_back(d);
    mdlCnt = mdlCnt + int'(wrOk) - int'(rdOk);
  endtask

  task automatic putWord(input bit r, input string tag);
    step(1'b1, nextWord, r, tag);
    nextWord = nextWord + 9'd1;
  endtask

  // Monitor: a quarter period after each rising edge, compare with the scoreboard.
  always @(posedge clk) begin
    #5;
    if (monOn) begin
      check(rdValid, expRd, "R4");
      if (rdValid && expRd) begin
        tests++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL %s: got word %h expected none", curTag, rdData);
        end else begin
          logic [DW-1:0] e;
          e = expQ.pop_front();
          if (rdData !== e) begin
            fails++;
            $display("FAIL %s: got word %h expected %h", curTag, rdData, e);
          end
        end
      end else if (!rdValid) begin
        tests++;
        if (rdData !== '0) begin
          fails++;
          $display("FAIL R4: idle bus got %h expected 0", rdData);
        end
      end
      expRd = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: flags during reset and just after
    repeat (2) @(negedge clk);
    check(emptyN, 1'b0, "R1");
    check(fullN, 1'b1, "R1");
    check(rdValid, 1'b0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    check(emptyN, 1'b0, "R1");
    check(fullN, 1'b1, "R1");
    check(rdValid, 1'b0, "R1");
    monOn = 1;

    // R3: read on empty is refused
    step(1'b0, '0, 1'b1, "R3");
    step(1'b0, '0, 1'b0, "R3");

    // R5/R6: cross the first cell boundary on both sides
    for (int i = 0; i < 6; i++) putWord(1'b0, "R5");
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1, "R6");
    step(1'b0, '0, 1'b0, "R6");

    // R7/R2: fill completely, then try extra writes
    for (int i = 0; i < CAP; i++) putWord(1'b0, "R7");
    step(1'b1, 9'h1AA, 1'b0, "R2");
    step(1'b1, 9'h155, 1'b0, "R2");
    // full with both strobes: read served, write dropped
    step(1'b1, 9'h0F0, 1'b1, "R2");
    putWord(1'b0, "R7");

    // R8/R3: drain completely, then try extra reads
    for (int i = 0; i < CAP; i++) step(1'b0, '0, 1'b1, "R6");
    step(1'b0, '0, 1'b1, "R3");
    // empty with both strobes: write taken, read refused
    putWord(1'b1, "R3");
    step(1'b0, '0, 1'b0, "R3");

    // R9/R10: steady simultaneous traffic wrapping the ring several times
    for (int i = 0; i < 5; i++) putWord(1'b0, "R9");
    for (int i = 0; i < 40; i++) putWord(1'b1, "R10");
    for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b1, "R10");

    // R10: irregular mix of reads and writes
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) putWord(lfsr[3] | lfsr[5], "R10");
      else step(1'b0, '0, lfsr[2] | lfsr[7], "R10");
    end
    while (mdlCnt > 0) step(1'b0, '0, 1'b1, "R10");
    step(1'b0, '0, 1'b0, "R8");
    step(1'b0, '0, 1'b0, "R8");
    @(negedge clk);
    check(emptyN, 1'b0, "R8");
    tests++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R5: got %0d words left expected 0", expQ.size());
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule